// File: doc/BRIEF.md
# Retention-Order Pair Comparison Hash

The block turns a challenge into a response word by comparing cells of a memory by their stored retention voltages. A challenge is a run of `NPAIRS` address pairs. For each pair the block reads the retention table four times: both polarity codes of the first address, then both codes of the second. It reduces each address to one value, the larger of its two codes, and emits one bit that says whether the second address holds at least the first one's value. Only the order of two values matters. Their absolute levels do not, so the response stays the same when every code drifts together.

Pairs come from two places. One is an external valid/ready stream. The other is a fixed internal store whose pairs are computed from a parameter and cannot be written. A lock input shuts the external stream. With lock set, only the internal store can supply a challenge, which is how a key-generation flow keeps an outside party from choosing challenges. The table port is a plain synchronous read with a fixed latency of `RD_LAT` cycles, so a block RAM can sit behind it directly.

Top module: `rvo_hash`

## Requirements
- R1: A challenge of `NPAIRS` pairs yields one `NPAIRS`-bit response on `resp_o`, where bit i belongs to the i-th accepted pair, so bit 0 is the first pair.
- R2: The value of an address is the maximum of its polarity-0 code and its polarity-1 code.
- R3: A response bit is 1 when value(second) >= value(first) and 0 otherwise, so equal values give 1.
- R4: The pairs (1,10), (6,9), (7,5) give bits 1,0,1 when address 10's value exceeds address 1's, address 6's exceeds address 9's, and address 5's exceeds address 7's.
- R5: While `lock_i` is 1, `ext_ready_o` is 0 and no external pair is consumed. A pair held on the stream during lock does not enter any response.
- R6: A one-cycle `start_store_i` while idle runs the internal challenge, whose pair i is first = (STORE_BASE + 2i) mod 2^AW and second = that value + 1 mod 2^AW. This works whether or not `lock_i` is set.
- R7: Each pair issues exactly four consecutive reads, in the order (first, pol 0), (first, pol 1), (second, pol 0), (second, pol 1), with `tbl_pol_o` giving the polarity. The code is expected on `tbl_code_i` `RD_LAT` cycles after the read cycle.
- R8: `resp_valid_o` is a one-cycle pulse when the last bit of a challenge is formed. `resp_o` holds its word until the next challenge completes.
- R9: After reset `resp_o` = 0, `resp_valid_o` = 0 and `tbl_rd_o` = 0. With `lock_i` low, `ext_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Closes the external challenge stream |
| start_store_i | input | 1 | Starts the internal stored challenge |
| ext_valid_i | input | 1 | External pair valid |
| ext_ready_o | output | 1 | External pair accepted this cycle when valid |
| ext_first_i | input | AW | External pair, first address |
| ext_second_i | input | AW | External pair, second address |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | AW | Table read address |
| tbl_pol_o | output | 1 | Polarity code selected by the read |
| tbl_code_i | input | VW | Code returned RD_LAT cycles after the read |
| resp_o | output | NPAIRS | Response word, bit 0 from the first pair |
| resp_valid_o | output | 1 | One-cycle pulse when resp_o updates |

## Verification
On every cycle the assertions check four things. A locked stream never shows ready. Reads inside a pair step through the four index positions in order, and a pair's last read is followed by an idle cycle. Equal values always give a 1 bit, and the valid flag never lasts two cycles. Several behaviours only the bench scenarios can show: the max-of-two reduction, bit placement within the word, the exact store pair formula, and the check that a pair held during lock is not consumed. The bench shows these by comparing whole responses against values computed from its own table contents. Those runs include an exhaustive sweep of all address pairs.

// File: rtl/rvo_pkg.sv
package rvo_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_STORE = 2'd2
  } src_state_e;

  localparam int READS_PER_PAIR = 4;
endpackage

// File: rtl/rvo_source.sv
module rvo_source
  import rvo_pkg::*;
#(
  parameter int AW         = 4,
  parameter int NPAIRS     = 4,
  parameter int STORE_BASE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_i,
  input  logic          start_store_i,
  input  logic          ext_valid_i,
  output logic          ext_ready_o,
  input  logic [AW-1:0] ext_first_i,
  input  logic [AW-1:0] ext_second_i,
  output logic          pair_valid_o,
  input  logic          pair_ready_i,
  output logic [AW-1:0] pair_first_o,
  output logic [AW-1:0] pair_second_o
);
  localparam int CW = $clog2(NPAIRS + 1);

  src_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          ext_open;
  logic          accept;
  logic [AW-1:0] store_first;

  // Internal store: fixed arithmetic sequence, not writable
  assign store_first = AW'(STORE_BASE) + AW'({cnt_q, 1'b0});

  assign ext_open    = ((state_q == SRC_IDLE) && !start_store_i) || (state_q == SRC_EXT);
  assign ext_ready_o = ext_open && pair_ready_i && !lock_i;

  always_comb begin
    if (state_q == SRC_STORE) begin
      pair_valid_o  = 1'b1;
      pair_first_o  = store_first;
      pair_second_o = store_first + AW'(1);
    end else begin
      pair_valid_o  = ext_valid_i && ext_open && !lock_i;
      pair_first_o  = ext_first_i;
      pair_second_o = ext_second_i;
    end
  end

  assign accept = pair_valid_o && pair_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_IDLE;
      cnt_q   <= '0;
    end else if (state_q == SRC_IDLE && start_store_i) begin
      state_q <= SRC_STORE;
      cnt_q   <= '0;
    end else if (accept) begin
      if (cnt_q == CW'(NPAIRS - 1)) begin
        state_q <= SRC_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        if (state_q == SRC_IDLE) state_q <= SRC_EXT;
      end
    end
  end

  assert_lock_no_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (ext_valid_i && ext_ready_o) |-> !lock_i);

  assert_store_no_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SRC_STORE) |-> !ext_ready_o);
endmodule

// File: rtl/rvo_fetch.sv
module rvo_fetch
  import rvo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int VW     = 8,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pair_valid_i,
  output logic          pair_ready_o,
  input  logic [AW-1:0] pair_first_i,
  input  logic [AW-1:0] pair_second_i,
  output logic          tbl_rd_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic          tbl_pol_o,
  input  logic [VW-1:0] tbl_code_i,
  output logic          codes_valid_o,
  output logic [VW-1:0] code_o [READS_PER_PAIR]
);
  logic          busy_q;
  logic          issuing_q;
  logic [1:0]    rd_idx_q;
  logic [AW-1:0] addr_a_q, addr_b_q;
  logic          tag_v_q   [RD_LAT];
  logic [1:0]    tag_idx_q [RD_LAT];
  logic          accept;
  logic [1:0]    next_idx;

  assign pair_ready_o = !busy_q;
  assign accept       = pair_valid_i && !busy_q;
  assign next_idx     = rd_idx_q + 2'd1;

  // Read issue: four reads per pair, index bit 1 picks address, bit 0 polarity
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      issuing_q  <= 1'b0;
      rd_idx_q   <= '0;
      addr_a_q   <= '0;
      addr_b_q   <= '0;
      tbl_rd_o   <= 1'b0;
      tbl_addr_o <= '0;
      tbl_pol_o  <= 1'b0;
    end else begin
      if (accept) begin
        busy_q     <= 1'b1;
        issuing_q  <= 1'b1;
        addr_a_q   <= pair_first_i;
        addr_b_q   <= pair_second_i;
        tbl_rd_o   <= 1'b1;
        tbl_addr_o <= pair_first_i;
        tbl_pol_o  <= 1'b0;
        rd_idx_q   <= 2'd0;
      end else if (issuing_q && rd_idx_q != 2'd3) begin
        tbl_rd_o   <= 1'b1;
        tbl_addr_o <= next_idx[1] ? addr_b_q : addr_a_q;
        tbl_pol_o  <= next_idx[0];
        rd_idx_q   <= next_idx;
      end else begin
        tbl_rd_o  <= 1'b0;
        issuing_q <= 1'b0;
      end
      if (tag_v_q[RD_LAT-1] && tag_idx_q[RD_LAT-1] == 2'd3) busy_q <= 1'b0;
    end
  end

  // Tag delay line matching the table latency
  genvar g;
  generate
    for (g = 0; g < RD_LAT; g++) begin : g_tag
      always_ff @(posedge clk) begin
        if (rst) begin
          tag_v_q[g]   <= 1'b0;
          tag_idx_q[g] <= '0;
        end else if (g == 0) begin
          tag_v_q[g]   <= tbl_rd_o;
          tag_idx_q[g] <= rd_idx_q;
        end else begin
          tag_v_q[g]   <= tag_v_q[(g == 0) ? 0 : g-1];
          tag_idx_q[g] <= tag_idx_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  // Return capture
  always_ff @(posedge clk) begin
    if (rst) begin
      codes_valid_o <= 1'b0;
      for (int k = 0; k < READS_PER_PAIR; k++) code_o[k] <= '0;
    end else begin
      codes_valid_o <= tag_v_q[RD_LAT-1] && (tag_idx_q[RD_LAT-1] == 2'd3);
      if (tag_v_q[RD_LAT-1]) code_o[tag_idx_q[RD_LAT-1]] <= tbl_code_i;
    end
  end

  assert_read_order_R7: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd_o && rd_idx_q != 2'd3) |=> (tbl_rd_o && rd_idx_q == $past(rd_idx_q) + 2'd1));

  assert_read_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd_o && rd_idx_q == 2'd3) |=> !tbl_rd_o);
endmodule

// File: rtl/rvo_compare.sv
module rvo_compare
  import rvo_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          codes_valid_i,
  input  logic [VW-1:0] code_i [READS_PER_PAIR],
  output logic          bit_valid_o,
  output logic          bit_o
);
  logic [VW-1:0] val_first, val_second;

  // Per-address value is the larger polarity code
  assign val_first  = (code_i[1] > code_i[0]) ? code_i[1] : code_i[0];
  assign val_second = (code_i[3] > code_i[2]) ? code_i[3] : code_i[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
    end else begin
      bit_valid_o <= codes_valid_i;
      if (codes_valid_i) bit_o <= (val_second >= val_first);
    end
  end

  assert_tie_gives_one_R3: assert property (@(posedge clk) disable iff (rst)
    (codes_valid_i && val_first == val_second) |=> (bit_valid_o && bit_o));
endmodule

// File: rtl/rvo_collect.sv
module rvo_collect #(
  parameter int NPAIRS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic [NPAIRS-1:0] resp_o,
  output logic              resp_valid_o
);
  localparam int CW = $clog2(NPAIRS + 1);

  logic [NPAIRS-1:0] sh_q;
  logic [NPAIRS-1:0] sh_next;
  logic [CW-1:0]     cnt_q;

  // Shift in at the top so the first pair ends up in bit 0
  generate
    if (NPAIRS == 1) begin : g_one
      assign sh_next = bit_i;
    end else begin : g_many
      assign sh_next = {bit_i, sh_q[NPAIRS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      resp_o       <= '0;
      resp_valid_o <= 1'b0;
    end else begin
      resp_valid_o <= 1'b0;
      if (bit_valid_i) begin
        sh_q <= sh_next;
        if (cnt_q == CW'(NPAIRS - 1)) begin
          cnt_q        <= '0;
          resp_o       <= sh_next;
          resp_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    resp_valid_o |=> !resp_valid_o);

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !resp_valid_o |-> $stable(resp_o));
endmodule

// File: rtl/rvo_hash.sv
module rvo_hash
  import rvo_pkg::*;
#(
  parameter int AW         = 4,
  parameter int VW         = 8,
  parameter int NPAIRS     = 4,
  parameter int RD_LAT     = 1,
  parameter int STORE_BASE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_i,
  input  logic              start_store_i,
  input  logic              ext_valid_i,
  output logic              ext_ready_o,
  input  logic [AW-1:0]     ext_first_i,
  input  logic [AW-1:0]     ext_second_i,
  output logic              tbl_rd_o,
  output logic [AW-1:0]     tbl_addr_o,
  output logic              tbl_pol_o,
  input  logic [VW-1:0]     tbl_code_i,
  output logic [NPAIRS-1:0] resp_o,
  output logic              resp_valid_o
);
  logic          pair_valid, pair_ready;
  logic [AW-1:0] pair_first, pair_second;
  logic          codes_valid;
  logic [VW-1:0] codes [READS_PER_PAIR];
  logic          bit_valid, bit_val;

  rvo_source #(.AW(AW), .NPAIRS(NPAIRS), .STORE_BASE(STORE_BASE)) u_src (
    .clk, .rst, .lock_i, .start_store_i, .ext_valid_i, .ext_ready_o,
    .ext_first_i, .ext_second_i,
    .pair_valid_o(pair_valid), .pair_ready_i(pair_ready),
    .pair_first_o(pair_first), .pair_second_o(pair_second)
  );

  rvo_fetch #(.AW(AW), .VW(VW), .RD_LAT(RD_LAT)) u_fetch (
    .clk, .rst,
    .pair_valid_i(pair_valid), .pair_ready_o(pair_ready),
    .pair_first_i(pair_first), .pair_second_i(pair_second),
    .tbl_rd_o, .tbl_addr_o, .tbl_pol_o, .tbl_code_i,
    .codes_valid_o(codes_valid), .code_o(codes)
  );

  rvo_compare #(.VW(VW)) u_cmp (
    .clk, .rst, .codes_valid_i(codes_valid), .code_i(codes),
    .bit_valid_o(bit_valid), .bit_o(bit_val)
  );

  rvo_collect #(.NPAIRS(NPAIRS)) u_col (
    .clk, .rst, .bit_valid_i(bit_valid), .bit_i(bit_val),
    .resp_o, .resp_valid_o
  );
endmodule

// File: tb/rvo_hash_tb.sv
module rvo_hash_tb_top;
  localparam int AW = 4, VW = 8, N = 4, LAT = 2, SB = 3;
  localparam int NA = 1 << AW;

  logic clk = 0, rst = 1;
  logic lock_i = 0, start_store_i = 0, ext_valid_i = 0;
  logic ext_ready_o;
  logic [AW-1:0] ext_first_i = '0, ext_second_i = '0;
  logic tbl_rd_o, tbl_pol_o;
  logic [AW-1:0] tbl_addr_o;
  logic [VW-1:0] tbl_code_i;
  logic [N-1:0] resp_o;
  logic resp_valid_o;

  int n_chk = 0, n_fail = 0;
  logic [VW-1:0] t0 [NA];
  logic [VW-1:0] t1 [NA];
  logic [VW-1:0] pipe [LAT+1];
  logic [AW:0] rlog [16];
  int rlog_n = 0;

  always #10 clk = ~clk;

  rvo_hash #(.AW(AW), .VW(VW), .NPAIRS(N), .RD_LAT(LAT), .STORE_BASE(SB)) dut_i (
    .clk, .rst, .lock_i, .start_store_i, .ext_valid_i, .ext_ready_o,
    .ext_first_i, .ext_second_i, .tbl_rd_o, .tbl_addr_o, .tbl_pol_o,
    .tbl_code_i, .resp_o, .resp_valid_o
  );

  // Table model: data reaches pipe[LAT] LAT cycles after the read cycle
  assign tbl_code_i = pipe[LAT];
  initial for (int k = 0; k <= LAT; k++) pipe[k] = '0;
  always @(negedge clk) begin
    for (int k = LAT; k > 0; k--) pipe[k] = pipe[k-1];
    pipe[0] = tbl_rd_o ? (tbl_pol_o ? t1[tbl_addr_o] : t0[tbl_addr_o]) : '0;
    if (tbl_rd_o && rlog_n < 16) begin
      rlog[rlog_n] = {tbl_addr_o, tbl_pol_o};
      rlog_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] valof(input int a);
    return (t1[a] > t0[a]) ? t1[a] : t0[a];
  endfunction

  function automatic logic [N-1:0] expect_resp(input logic [N*AW-1:0] fv, input logic [N*AW-1:0] sv);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = valof(sv[i*AW +: AW]) >= valof(fv[i*AW +: AW]);
    return r;
  endfunction

  task automatic fill_table();
    for (int a = 0; a < NA; a++) begin
      t0[a] = VW'((a * 37 + 11) % 256);
      t1[a] = VW'((a * 91 + 5) % 256);
    end
  endtask

  task automatic send_pair(input logic [AW-1:0] f, input logic [AW-1:0] s);
    @(negedge clk);
    ext_valid_i = 1; ext_first_i = f; ext_second_i = s;
    while (!ext_ready_o) @(negedge clk);
    @(negedge clk);
    ext_valid_i = 0;
  endtask

  task automatic wait_resp(output logic [N-1:0] r, output bit got);
    got = 0; r = '0;
    for (int k = 0; k < 400; k++) begin
      if (resp_valid_o) begin got = 1; r = resp_o; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_ext(input logic [N*AW-1:0] fv, input logic [N*AW-1:0] sv,
                         input string req);
    logic [N-1:0] r; bit got;
    for (int i = 0; i < N; i++) send_pair(fv[i*AW +: AW], sv[i*AW +: AW]);
    wait_resp(r, got);
    chk(got, req, got, 1);
    chk(r == expect_resp(fv, sv), req, r, expect_resp(fv, sv));
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] fv, sv;
    logic [N-1:0] r;
    bit got;
    int seen;
    fill_table();
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(resp_o == 0, "R9 resp", resp_o, 0);
    chk(resp_valid_o == 0, "R9 valid", resp_valid_o, 0);
    chk(tbl_rd_o == 0, "R9 rd", tbl_rd_o, 0);
    chk(ext_ready_o == 1, "R9 ready", ext_ready_o, 1);

    // R4 test vector, with R7 read order logged
    t0[1] = 10;  t1[1] = 20;  t0[10] = 90;  t1[10] = 5;
    t0[6] = 200; t1[6] = 3;   t0[9] = 40;   t1[9] = 60;
    t0[7] = 11;  t1[7] = 12;  t0[5] = 77;   t1[5] = 1;
    rlog_n = 0;
    fv = {4'd0, 4'd7, 4'd6, 4'd1};
    sv = {4'd0, 4'd5, 4'd9, 4'd10};
    for (int i = 0; i < N; i++) send_pair(fv[i*AW +: AW], sv[i*AW +: AW]);
    wait_resp(r, got);
    chk(got && r == 4'b1101, "R4", r, 4'b1101);
    chk(rlog[0] == {4'd1, 1'b0}, "R7 read0", rlog[0], {4'd1, 1'b0});
    chk(rlog[1] == {4'd1, 1'b1}, "R7 read1", rlog[1], {4'd1, 1'b1});
    chk(rlog[2] == {4'd10, 1'b0}, "R7 read2", rlog[2], {4'd10, 1'b0});
    chk(rlog[3] == {4'd10, 1'b1}, "R7 read3", rlog[3], {4'd10, 1'b1});
    chk(rlog[4] == {4'd6, 1'b0}, "R7 read4", rlog[4], {4'd6, 1'b0});
    @(negedge clk);
    chk(resp_valid_o == 0 && resp_o == 4'b1101, "R8 pulse/hold", resp_o, 4'b1101);

    // R2 max of polarities, R3 tie resolves to 1
    t0[4] = 200; t1[4] = 10;  t0[8] = 30;  t1[8] = 150;
    t0[2] = 50;  t1[2] = 100; t0[3] = 100; t1[3] = 20;
    fv = {4'd3, 4'd2, 4'd8, 4'd4};
    sv = {4'd2, 4'd3, 4'd4, 4'd8};
    for (int i = 0; i < N; i++) send_pair(fv[i*AW +: AW], sv[i*AW +: AW]);
    wait_resp(r, got);
    chk(got && r == 4'b1110, "R2 R3 directed", r, 4'b1110);
    @(negedge clk);

    // R5 lock blocks external stream
    lock_i = 1;
    ext_valid_i = 1; ext_first_i = 4'd4; ext_second_i = 4'd8;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ext_ready_o) seen++;
      if (resp_valid_o) seen++;
    end
    chk(seen == 0, "R5 locked", seen, 0);
    chk(resp_o == 4'b1110, "R5 resp unchanged", resp_o, 4'b1110);

    // R6 store challenge under lock
    start_store_i = 1;
    @(negedge clk);
    start_store_i = 0;
    for (int i = 0; i < N; i++) begin
      fv[i*AW +: AW] = AW'(SB + 2 * i);
      sv[i*AW +: AW] = AW'(SB + 2 * i + 1);
    end
    wait_resp(r, got);
    chk(got && r == expect_resp(fv, sv), "R6 store", r, expect_resp(fv, sv));
    @(negedge clk);
    ext_valid_i = 0;
    @(negedge clk);
    lock_i = 0;
    // R5: after unlock the held pair must not have entered any response
    fv = {4'd0, 4'd7, 4'd6, 4'd1};
    sv = {4'd0, 4'd5, 4'd9, 4'd10};
    run_ext(fv, sv, "R5 post-unlock alignment");

    // R1 R3 exhaustive sweep over all address pairs
    fill_table();
    for (int c = 0; c < NA * NA / N; c++) begin
      for (int i = 0; i < N; i++) begin
        fv[i*AW +: AW] = AW'((c * N + i) / NA);
        sv[i*AW +: AW] = AW'((c * N + i) % NA);
      end
      run_ext(fv, sv, "R1 R3 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule